// File: doc/BRIEF.md
# Iterative Single-Precision Floating-Point Divider

This block divides one 32-bit binary floating-point word by another. The sign of the result is formed from the two operand signs. The exponent is the dividend's stored exponent minus the divisor's, with the bias of 127 added back. The significand quotient comes from a restoring shift-and-subtract loop that makes one quotient bit per clock. That loop produces 25 bits: one integer bit and 24 fraction bits. Because both significands are normalized, the quotient lies in [0.5, 2). A single conditional left shift, with a matching exponent decrement, is therefore enough to normalize it. Extra quotient bits are truncated.

A caller places two operands on the inputs and pulses `start`. The block then raises `busy` and ignores `start` until it finishes. At the end it presents the packed result together with a divide-by-zero flag and pulses `done` for one cycle. The result and flag hold their values until the next operation completes.

Operands are classified by their exponent field. A field of all ones marks infinity when the fraction is zero and NaN otherwise. A field of zero is treated as zero, whatever the fraction holds. NaN results always come out as the quiet pattern 0x7FC00000.

Top module: `fpq_div_top`

## Requirements
- R1: While reset is high, and after it is released until the first completion, `busy`, `done`, `quot` and `div_zero` are all 0.
- R2: A `start` seen while `busy` is low is accepted on that clock edge, and `busy` is high from the next cycle until completion.
- R3: A `start` pulse while `busy` is high is ignored. The running operation's result and timing are unchanged, and no second completion follows.
- R4: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R5: For normal operands, the result is the truncated quotient of the significands (with the hidden bit) and the biased exponent difference. For example, 6.0/2.0 gives 0x40400000.
- R6: When the significand quotient is below 1, it is shifted left once and the exponent is lowered by one. For example, 1.0/3.0 gives 0x3EAAAAAA and 1.0/1.5 gives 0x3F2AAAAA.
- R7: The result sign bit (bit 31) is the XOR of the operand sign bits, including on zero and infinity results.
- R8: A finite non-zero dividend divided by a zero divisor (exponent field 0, any fraction) gives a signed infinity (exponent field 0xFF, fraction 0) and sets `div_zero` to 1.
- R9: A NaN operand, zero divided by zero, or infinity divided by infinity gives 0x7FC00000 with `div_zero` = 0.
- R10: Infinity divided by a finite value gives a signed infinity. A finite value divided by infinity gives a signed zero. A zero dividend (including a denormal) divided by a finite non-zero value gives a signed zero. `div_zero` is 0 in all of these cases.
- R11: A biased result exponent of 255 or more gives a signed infinity. A biased result exponent of 0 or less gives a signed zero.
- R12: `done` rises on the 26th rising clock edge after the edge that accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division with the current operands |
| op_a | input | 32 | Dividend word |
| op_b | input | 32 | Divisor word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quot | output | 32 | Packed quotient, held until the next completion |
| div_zero | output | 1 | Finite non-zero divided by zero, held with `quot` |

## Verification
Two quotients that fall in [1, 2) and two that fall below 1 are checked against exact truncated bit patterns. This separates the unshifted normalization path from the shifted one and exposes an exponent that is off by one. Operand pairs with mixed signs, and zero and infinity results with mixed signs, show whether the sign is formed independently of the value path. The special-value table is checked entry by entry. Every entry uses a sign and zero-class encoding that, if the classification priority were wrong, would produce a different word or a different flag. That includes a denormal divisor, a denormal dividend, and 0/0 against x/0. The handshake is checked with a stray `start` in the middle of an operation. The bench verifies the latency in edges, the one-cycle `done`, and the absence of any phantom second result.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  typedef enum logic [1:0] {
    FPQ_ZERO = 2'd0,
    FPQ_NORM = 2'd1,
    FPQ_INF  = 2'd2,
    FPQ_NAN  = 2'd3
  } fpq_class_e;
endpackage

// File: rtl/fpq_unpack.sv
module fpq_unpack
  import fpq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      expo,
  output fpq_class_e            cls
);
  logic [FRAC_W-1:0] frac;

  always_comb begin
    sign = word[EXP_W+FRAC_W];
    expo = word[FRAC_W +: EXP_W];
    frac = word[FRAC_W-1:0];
    if (&expo)
      cls = (frac == '0) ? FPQ_INF : FPQ_NAN;
    else if (expo == '0)
      cls = FPQ_ZERO;   // denormals flushed to zero
    else
      cls = FPQ_NORM;
  end
endmodule

// File: rtl/fpq_restore_core.sv
module fpq_restore_core #(
  parameter int SIG_W = 24,
  parameter int ITERS = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SIG_W-1:0] dividend,
  input  logic [SIG_W-1:0] divisor,
  output logic [ITERS-1:0] quo,
  output logic             fin
);
  localparam int REM_W = SIG_W + 2;
  localparam int CNT_W = $clog2(ITERS + 1);

  logic [REM_W-1:0] rem;
  logic [SIG_W-1:0] div_r;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [REM_W-1:0] diff;
  logic             fits;

  always_comb begin
    fits = rem >= {2'b00, div_r};
    diff = rem - {2'b00, div_r};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      div_r <= '0;
      quo   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem   <= {2'b00, dividend};
        div_r <= divisor;
        quo   <= '0;
        cnt   <= '0;
        run   <= 1'b1;
      end else if (run) begin
        if (fits) begin
          rem <= {diff[REM_W-2:0], 1'b0};
          quo <= {quo[ITERS-2:0], 1'b1};
        end else begin
          rem <= {rem[REM_W-2:0], 1'b0};
          quo <= {quo[ITERS-2:0], 1'b0};
        end
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(ITERS - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  // R5: partial remainder always below twice the divisor while iterating
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run |-> (rem < {1'b0, div_r, 1'b0}));

  // R4: completion from the loop is a single-cycle pulse
  p_fin_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/fpq_pack.sv
module fpq_pack
  import fpq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int ITERS  = FRAC_W + 2
) (
  input  logic                  sign_a,
  input  logic                  sign_b,
  input  logic [EXP_W-1:0]      exp_a,
  input  logic [EXP_W-1:0]      exp_b,
  input  fpq_class_e            cls_a,
  input  fpq_class_e            cls_b,
  input  logic [ITERS-1:0]      quo,
  output logic [EXP_W+FRAC_W:0] word,
  output logic                  dz
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam int EW2  = EXP_W + 2;

  logic                    sgn;
  logic signed [EW2-1:0]   e_res;
  logic [FRAC_W-1:0]       frac_res;
  logic [EXP_W+FRAC_W:0]   inf_w, zero_w, qnan_w;

  always_comb begin
    sgn    = sign_a ^ sign_b;
    inf_w  = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    zero_w = {sgn, {(EXP_W + FRAC_W){1'b0}}};
    qnan_w = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W - 1){1'b0}}};
    // integer bit set: quotient in [1,2); else shift left one place
    e_res  = EW2'(exp_a) - EW2'(exp_b) + EW2'(BIAS) - EW2'(!quo[ITERS-1]);
    frac_res = quo[ITERS-1] ? quo[ITERS-2 -: FRAC_W] : quo[ITERS-3 -: FRAC_W];
    dz = 1'b0;
    if (cls_a == FPQ_NAN || cls_b == FPQ_NAN ||
        (cls_a == FPQ_ZERO && cls_b == FPQ_ZERO) ||
        (cls_a == FPQ_INF && cls_b == FPQ_INF)) begin
      word = qnan_w;
    end else if (cls_a == FPQ_INF) begin
      word = inf_w;
    end else if (cls_b == FPQ_INF) begin
      word = zero_w;
    end else if (cls_b == FPQ_ZERO) begin
      word = inf_w;
      dz   = 1'b1;
    end else if (cls_a == FPQ_ZERO) begin
      word = zero_w;
    end else if (e_res >= EMAX) begin
      word = inf_w;
    end else if (e_res <= 0) begin
      word = zero_w;
    end else begin
      word = {sgn, e_res[EXP_W-1:0], frac_res};
    end
  end
endmodule

// File: rtl/fpq_div_top.sv
module fpq_div_top
  import fpq_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  output logic                    busy,
  output logic                    done,
  output logic [EXP_W+FRAC_W:0]   quot,
  output logic                    div_zero
);
  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int SIG_W = FRAC_W + 1;
  localparam int ITERS = FRAC_W + 2;
  localparam int LAT_W = $clog2(ITERS + 2) + 1;

  logic             accept;
  logic [W-1:0]     opr [2];
  logic             sgn [2];
  logic [EXP_W-1:0] ex  [2];
  fpq_class_e       cl  [2];
  logic [ITERS-1:0] core_quo;
  logic             core_fin;
  logic [W-1:0]     pack_word;
  logic             pack_dz;

  assign accept = start && !busy;

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_opnd
      fpq_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
        .word (opr[gi]),
        .sign (sgn[gi]),
        .expo (ex[gi]),
        .cls  (cl[gi])
      );
    end
  endgenerate

  fpq_restore_core #(.SIG_W(SIG_W), .ITERS(ITERS)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .dividend ({1'b1, op_a[FRAC_W-1:0]}),
    .divisor  ({1'b1, op_b[FRAC_W-1:0]}),
    .quo      (core_quo),
    .fin      (core_fin)
  );

  fpq_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .ITERS(ITERS)) u_pack (
    .sign_a (sgn[0]),
    .sign_b (sgn[1]),
    .exp_a  (ex[0]),
    .exp_b  (ex[1]),
    .cls_a  (cl[0]),
    .cls_b  (cl[1]),
    .quo    (core_quo),
    .word   (pack_word),
    .dz     (pack_dz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opr[0]   <= '0;
      opr[1]   <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      quot     <= '0;
      div_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        opr[0] <= op_a;
        opr[1] <= op_b;
        busy   <= 1'b1;
      end
      if (core_fin) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        quot     <= pack_word;
        div_zero <= pack_dz;
      end
    end
  end

  // cycle counter used only by the latency check
  logic [LAT_W-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst)         lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy)   lat_cnt <= lat_cnt + 1'b1;
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !core_fin) |=> (busy && $stable(opr[0]) && $stable(opr[1])));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_dz_inf_r8: assert property (@(posedge clk) disable iff (rst)
    (done && div_zero) |-> (quot[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  p_nan_noflag_r9: assert property (@(posedge clk) disable iff (rst)
    (done && (&quot[W-2 -: EXP_W]) && (quot[FRAC_W-1:0] != '0)) |-> !div_zero);

  p_latency_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == LAT_W'(ITERS + 1)));
endmodule

// File: tb/fpq_div_top_tb_top.sv
`timescale 1ns/100ps
module fpq_div_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        busy, done, div_zero;
  logic [31:0] quot;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam int EXP_LAT = 26;

  always #2.5 clk = ~clk;

  fpq_div_top dut_i (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .quot(quot), .div_zero(div_zero)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // run one division; returns result, flag, latency and handshake health
  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] res, output logic dz,
                        output int lat, output bit hs_ok);
    hs_ok = 1'b1;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    if (!busy) hs_ok = 1'b0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      if (!done && !busy) hs_ok = 1'b0;
    end
    if (busy) hs_ok = 1'b0;
    res = quot; dz = div_zero;
    @(negedge clk);
    if (done) hs_ok = 1'b0;
  endtask

  task automatic expect_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] exp_w, input logic exp_dz);
    logic [31:0] r; logic d; int l; bit h;
    run_op(a, b, r, d, l, h);
    chk({tag, " result"}, r, exp_w);
    chk({tag, " flag"}, {31'd0, d}, {31'd0, exp_dz});
  endtask

  task automatic t_reset_r1();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 quot", quot, 32'd0);
    chk("R1 flag", {31'd0, div_zero}, 32'd0);
  endtask

  task automatic t_normal_r5();
    expect_op("R5 6/2", 32'h40C00000, 32'h40000000, 32'h40400000, 1'b0);
    expect_op("R5 7/4", 32'h40E00000, 32'h40800000, 32'h3FE00000, 1'b0);
  endtask

  task automatic t_shift_r6();
    expect_op("R6 1/3", 32'h3F800000, 32'h40400000, 32'h3EAAAAAA, 1'b0);
    expect_op("R6 1/1.5", 32'h3F800000, 32'h3FC00000, 32'h3F2AAAAA, 1'b0);
  endtask

  task automatic t_sign_r7();
    expect_op("R7 -7.5/2.5", 32'hC0F00000, 32'h40200000, 32'hC0400000, 1'b0);
    expect_op("R7 10/-4", 32'h41200000, 32'hC0800000, 32'hC0200000, 1'b0);
    expect_op("R7 -6/-2", 32'hC0C00000, 32'hC0000000, 32'h40400000, 1'b0);
  endtask

  task automatic t_divzero_r8();
    expect_op("R8 5/0", 32'h40A00000, 32'h00000000, 32'h7F800000, 1'b1);
    expect_op("R8 -5/+0", 32'hC0A00000, 32'h00000000, 32'hFF800000, 1'b1);
    expect_op("R8 1/denormal", 32'h3F800000, 32'h00000001, 32'h7F800000, 1'b1);
  endtask

  task automatic t_nan_r9();
    expect_op("R9 0/0", 32'h00000000, 32'h80000000, 32'h7FC00000, 1'b0);
    expect_op("R9 inf/inf", 32'h7F800000, 32'hFF800000, 32'h7FC00000, 1'b0);
    expect_op("R9 nan/1", 32'h7F800001, 32'h3F800000, 32'h7FC00000, 1'b0);
    expect_op("R9 1/nan", 32'h3F800000, 32'hFFC00000, 32'h7FC00000, 1'b0);
  endtask

  task automatic t_special_r10();
    expect_op("R10 -inf/2", 32'hFF800000, 32'h40000000, 32'hFF800000, 1'b0);
    expect_op("R10 2/-inf", 32'h40000000, 32'hFF800000, 32'h80000000, 1'b0);
    expect_op("R10 0/3", 32'h00000000, 32'h40400000, 32'h00000000, 1'b0);
    expect_op("R10 denormal/-1", 32'h00000005, 32'hBF800000, 32'h80000000, 1'b0);
    expect_op("R10 inf/0", 32'h7F800000, 32'h00000000, 32'h7F800000, 1'b0);
  endtask

  task automatic t_range_r11();
    expect_op("R11 overflow", 32'h7F000000, 32'h00800000, 32'h7F800000, 1'b0);
    expect_op("R11 -overflow", 32'hFF000000, 32'h00800000, 32'hFF800000, 1'b0);
    expect_op("R11 underflow", 32'h00800000, 32'hC0000000, 32'h80000000, 1'b0);
    expect_op("R11 smallest normal", 32'h01000000, 32'h40000000, 32'h00800000, 1'b0);
  endtask

  task automatic t_handshake_r2_r4_r12();
    logic [31:0] r; logic d; int l; bit h;
    run_op(32'h41000000, 32'h40000000, r, d, l, h);
    chk("R12 latency", l, EXP_LAT);
    chk("R2/R4 handshake", {31'd0, h}, 32'd1);
    chk("R5 8/2", r, 32'h40800000);
  endtask

  task automatic t_busy_ignore_r3();
    int l = 0;
    int extra = 0;
    @(negedge clk);
    op_a = 32'h40C00000; op_b = 32'h40000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && l < 100) begin
      @(negedge clk);
      l++;
      if (l == 5) begin
        op_a = 32'h40A00000; op_b = 32'h00000000; start = 1'b1;
      end else if (l == 6) begin
        start = 1'b0;
      end
    end
    chk("R3 result", quot, 32'h40400000);
    chk("R3 flag", {31'd0, div_zero}, 32'd0);
    chk("R3 latency", l, EXP_LAT);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i > 0 && done) extra++;
      if (busy) extra++;
    end
    chk("R3 no second run", extra, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_r1();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_r1();
    t_handshake_r2_r4_r12();
    t_normal_r5();
    t_shift_r6();
    t_sign_r7();
    t_divzero_r8();
    t_nan_r9();
    t_special_r10();
    t_range_r11();
    t_busy_ignore_r3();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule